// File: doc/BRIEF.md
# Viterbi Traceback Survivor Memory (4-state)

This block keeps the decision bits that an add-compare-select stage produces for a four-state rate-1/n convolutional code and turns them back into decoded information bits. Every accepted input beat is one trellis stage. It carries one decision bit per state and a hint naming the state that currently has the best metric. The decisions go into a column of a banked memory. One bank is written while a tracer walks the two older banks backwards. The newer of the two older banks serves only to let the survivor paths merge. Bits are decoded out of the older one.

Decoded bits come out in reverse order as the tracer walks back. A small reorder buffer puts them back in time order. Each accepted input beat yields exactly one output beat. Output beat k carries the information bit of stage k-48. A flag marks whether a beat is meaningful: it is low for beats that leave before the first complete traceback.

The input and output are valid/ready streams and share one stall rule. The block has a one-deep output register and accepts a new stage only when that register is empty or is being drained in the same cycle. When downstream holds `out_ready` low, the output beat stays frozen. When the output register is full, the input stalls as well, so a stage never enters without a slot for its output beat.

Top module: `surv_traceback`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A stage is taken only in a cycle where both `in_valid` and `in_ready` are high.
- R2: Every accepted stage makes `out_valid` high in the next cycle. When an output beat is taken and no stage is accepted in that cycle, `out_valid` is low in the next cycle.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bit` and `out_ok` keep their values into the next cycle.
- R4: Output beats follow input stages in order. When `out_ok` is high, output beat k carries the information bit of input stage k-48 (three banks of 16 stages).
- R5: Bit r of `in_dec` is the least significant bit of the predecessor of state r. A state takes each new input bit at its most significant position. One traceback step moves from state s to ((s << 1) AND 3) XOR decision[s], and the decoded bit at state s is its most significant bit.
- R6: With FIXED_START = 0, each traceback starts from the `in_best` value accepted with the stage that fills the last column (index 15) of a bank. `in_best` on every other stage has no effect on the output.
- R7: With FIXED_START = 1, `in_best` is ignored and every traceback starts from state 0.
- R8: `out_ok` is low on the first 48 output beats and high on every later beat.
- R9: During reset and in the first cycle after it, `out_valid` and `out_ok` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A stage of decisions is offered |
| in_ready | output | 1 | The block takes the offered stage |
| in_dec | input | 2^STATE_BITS | One decision bit per state, bit r for state r |
| in_best | input | STATE_BITS | State holding the best metric at this stage |
| out_valid | output | 1 | An output beat is present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_bit | output | 1 | Decoded information bit |
| out_ok | output | 1 | The beat comes from a complete traceback |

## Verification
The bench builds two copies with the default four-state code and 16-column banks. One copy starts its traceback from the supplied best state, and the other starts from state 0. The stimulus is 640 stages, so the 48-stage pipeline fills and every bank takes each of its three roles many times. The input streams follow a random encoder path. The path fed to the fixed-start copy is forced through state 0 at the end of every bank, and the best-state hint is random except on the last column of a bank. Both start modes and the rule that only that one column's hint counts can therefore be seen in the decoded stream. The bench first runs at full rate and then applies random input gaps and random back-pressure.

// File: rtl/surv_pkg.sv
`timescale 1ns/1ps
package surv_pkg;

  // Role of the tracer within the current segment of 16 stages.
  typedef enum logic {
    PH_CONVERGE = 1'b0,
    PH_DECODE   = 1'b1
  } trace_phase_e;

  localparam int unsigned MAX_SB = 8;

  // One step back through the trellis: shift the state up, keep it inside the
  // state range, and fill the vacated low bit with the stored decision.
  function automatic logic [MAX_SB-1:0] step_back(
    input logic [MAX_SB-1:0] row,
    input logic              dec,
    input logic [MAX_SB-1:0] mask
  );
    return ((row << 1) & mask) ^ {{(MAX_SB-1){1'b0}}, dec};
  endfunction

endpackage

// File: rtl/surv_ctrl.sv
`timescale 1ns/1ps
module surv_ctrl
  import surv_pkg::*;
#(
  parameter int COLS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic [$clog2(COLS)-1:0] col,
  output logic [1:0]              wr_bank,
  output logic [1:0]              conv_bank,
  output logic [1:0]              dec_bank,
  output trace_phase_e            phase,
  output logic                    mature
);

  localparam int CW  = $clog2(COLS);
  localparam int LAT = 3 * COLS;
  localparam int LW  = $clog2(LAT + 1);

  logic [LW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col     <= '0;
      wr_bank <= '0;
      seen_q  <= '0;
    end else if (adv) begin
      if (col == CW'(COLS - 1)) begin
        col     <= '0;
        wr_bank <= (wr_bank == 2'd2) ? 2'd0 : wr_bank + 2'd1;
      end else begin
        col <= col + CW'(1);
      end
      if (seen_q != LW'(LAT)) begin
        seen_q <= seen_q + LW'(1);
      end
    end
  end

  // The bank filled last gives the paths room to merge; the one before it is decoded.
  assign conv_bank = (wr_bank == 2'd0) ? 2'd2 : wr_bank - 2'd1;
  assign dec_bank  = (wr_bank == 2'd2) ? 2'd0 : wr_bank + 2'd1;
  assign phase     = (int'(col) < COLS / 2) ? PH_CONVERGE : PH_DECODE;
  assign mature    = (seen_q == LW'(LAT));

endmodule

// File: rtl/surv_bank.sv
`timescale 1ns/1ps
module surv_bank #(
  parameter int NS   = 4,
  parameter int COLS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(COLS)-1:0] wr_col,
  input  logic [NS-1:0]           wr_dec,
  input  logic [$clog2(COLS)-1:0] rd_col_a,
  input  logic [$clog2(NS)-1:0]   rd_row_a,
  input  logic [$clog2(COLS)-1:0] rd_col_b,
  input  logic [$clog2(NS)-1:0]   rd_row_b,
  output logic                    rd_bit_a,
  output logic                    rd_bit_b
);

  // One word per stage, one bit per state inside the word.
  logic [NS-1:0] cells_q [COLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) begin
        cells_q[c] <= '0;
      end
    end else if (we) begin
      cells_q[wr_col] <= wr_dec;
    end
  end

  assign rd_bit_a = cells_q[rd_col_a][rd_row_a];
  assign rd_bit_b = cells_q[rd_col_b][rd_row_b];

endmodule

// File: rtl/surv_tracer.sv
`timescale 1ns/1ps
module surv_tracer
  import surv_pkg::*;
#(
  parameter int SB          = 2,
  parameter int COLS        = 16,
  parameter bit FIXED_START = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic [$clog2(COLS)-1:0] col,
  input  trace_phase_e            phase,
  input  logic [SB-1:0]           start_in,
  input  logic                    bit_a,
  input  logic                    bit_b,
  output logic [$clog2(COLS)-1:0] col_a,
  output logic [SB-1:0]           row_a,
  output logic [$clog2(COLS)-1:0] col_b,
  output logic [SB-1:0]           row_b,
  output logic                    u_a,
  output logic                    u_b
);

  localparam int CW   = $clog2(COLS);
  localparam int MASK = (1 << SB) - 1;

  logic [SB-1:0] trace_q;
  logic [SB-1:0] start_q;
  logic [SB-1:0] start_pick;
  logic [SB-1:0] row_n;
  int            ca;

  generate
    if (FIXED_START) begin : g_zero_start
      assign start_pick = '0;
    end else begin : g_best_start
      assign start_pick = start_in;
    end
  endgenerate

  // Two steps per stage: 16 steps to merge through one bank, 16 to decode the next.
  always_comb begin
    if (phase == PH_CONVERGE) begin
      ca = COLS - 1 - 2 * int'(col);
    end else begin
      ca = 2 * COLS - 1 - 2 * int'(col);
    end
  end

  assign col_a = CW'(ca);
  assign col_b = CW'(ca - 1);

  assign row_a = (col == '0) ? start_q : trace_q;
  assign row_b = SB'(step_back(MAX_SB'(row_a), bit_a, MAX_SB'(MASK)));
  assign row_n = SB'(step_back(MAX_SB'(row_b), bit_b, MAX_SB'(MASK)));

  // The newest input bit of a state sits in its top bit.
  assign u_a = row_a[SB-1];
  assign u_b = row_b[SB-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trace_q <= '0;
      start_q <= '0;
    end else if (adv) begin
      trace_q <= row_n;
      if (col == CW'(COLS - 1)) begin
        start_q <= start_pick;
      end
    end
  end

endmodule

// File: rtl/surv_reorder.sv
`timescale 1ns/1ps
module surv_reorder
  import surv_pkg::*;
#(
  parameter int COLS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    out_ready,
  input  logic [$clog2(COLS)-1:0] col,
  input  trace_phase_e            phase,
  input  logic [$clog2(COLS)-1:0] col_a,
  input  logic [$clog2(COLS)-1:0] col_b,
  input  logic                    u_a,
  input  logic                    u_b,
  input  logic                    mature,
  output logic                    in_ready,
  output logic                    adv,
  output logic                    out_valid,
  output logic                    out_bit,
  output logic                    out_ok
);

  localparam int CW = $clog2(COLS);

  logic [COLS-1:0] gather_q;
  logic [COLS-1:0] gather_d;
  logic [COLS-1:0] play_q;

  // Bits arrive newest first; storing them by column undoes the reversal.
  always_comb begin
    gather_d = gather_q;
    if (phase == PH_DECODE) begin
      gather_d[col_a] = u_a;
      gather_d[col_b] = u_b;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gather_q  <= '0;
      play_q    <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_ok    <= 1'b0;
    end else if (adv) begin
      gather_q  <= gather_d;
      if (col == CW'(COLS - 1)) begin
        play_q <= gather_d;
      end
      out_valid <= 1'b1;
      out_bit   <= play_q[col];
      out_ok    <= mature;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/surv_traceback.sv
`timescale 1ns/1ps
module surv_traceback
  import surv_pkg::*;
#(
  parameter int STATE_BITS  = 2,
  parameter int COLS        = 16,
  parameter bit FIXED_START = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [(1<<STATE_BITS)-1:0] in_dec,
  input  logic [STATE_BITS-1:0]      in_best,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_bit,
  output logic                       out_ok
);

  localparam int NS = 1 << STATE_BITS;
  localparam int CW = $clog2(COLS);
  localparam int NB = 3;

  logic                  adv;
  logic [CW-1:0]         col;
  logic [1:0]            wr_bank;
  logic [1:0]            conv_bank;
  logic [1:0]            dec_bank;
  logic [1:0]            rd_bank;
  trace_phase_e          phase;
  logic                  mature;
  logic [CW-1:0]         col_a;
  logic [CW-1:0]         col_b;
  logic [STATE_BITS-1:0] row_a;
  logic [STATE_BITS-1:0] row_b;
  logic                  bit_a;
  logic                  bit_b;
  logic                  u_a;
  logic                  u_b;
  logic [NB-1:0]         bank_a;
  logic [NB-1:0]         bank_b;

  surv_ctrl #(.COLS(COLS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .col       (col),
    .wr_bank   (wr_bank),
    .conv_bank (conv_bank),
    .dec_bank  (dec_bank),
    .phase     (phase),
    .mature    (mature)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    surv_bank #(.NS(NS), .COLS(COLS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (adv && (wr_bank == 2'(b))),
      .wr_col   (col),
      .wr_dec   (in_dec),
      .rd_col_a (col_a),
      .rd_row_a (row_a),
      .rd_col_b (col_b),
      .rd_row_b (row_b),
      .rd_bit_a (bank_a[b]),
      .rd_bit_b (bank_b[b])
    );
  end

  assign rd_bank = (phase == PH_CONVERGE) ? conv_bank : dec_bank;
  assign bit_a   = bank_a[rd_bank];
  assign bit_b   = bank_b[rd_bank];

  surv_tracer #(.SB(STATE_BITS), .COLS(COLS), .FIXED_START(FIXED_START)) u_tracer (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .col      (col),
    .phase    (phase),
    .start_in (in_best),
    .bit_a    (bit_a),
    .bit_b    (bit_b),
    .col_a    (col_a),
    .row_a    (row_a),
    .col_b    (col_b),
    .row_b    (row_b),
    .u_a      (u_a),
    .u_b      (u_b)
  );

  surv_reorder #(.COLS(COLS)) u_reorder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .col       (col),
    .phase     (phase),
    .col_a     (col_a),
    .col_b     (col_b),
    .u_a       (u_a),
    .u_b       (u_b),
    .mature    (mature),
    .in_ready  (in_ready),
    .adv       (adv),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_ok    (out_ok)
  );

endmodule

// File: rtl/surv_traceback_chk.sv
`timescale 1ns/1ps
module surv_traceback_chk #(
  parameter int COLS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_ok
);

  localparam int LAT = 3 * COLS;
  localparam int LW  = $clog2(LAT + 2);

  logic [LW-1:0] taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= '0;
    end else if (in_valid && in_ready && (taken_q != LW'(LAT + 1))) begin
      taken_q <= taken_q + LW'(1);
    end
  end

  p_stall_blocks_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_accept_gives_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_hold_under_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_ok)));

  p_flag_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(taken_q) <= LAT) |-> !out_ok);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ok |=> out_ok);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r9: assert (!out_valid && !out_ok && in_ready);
    end
  end

endmodule

bind surv_traceback surv_traceback_chk #(.COLS(COLS)) u_chk (.*);

// File: tb/tb_surv_traceback.sv
`timescale 1ns/1ps
module tb_surv_traceback;

  localparam int COLS = 16;
  localparam int LAT  = 3 * COLS;
  localparam int N    = 640;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       in_valid = 1'b0;
  logic       out_ready = 1'b0;
  logic [3:0] dec_a = '0;
  logic [3:0] dec_z = '0;
  logic [1:0] best_a = '0;
  logic [1:0] best_z = '0;
  logic       rdy_a, rdy_z, ov_a, ov_z, ob_a, ob_z, ok_a, ok_z;

  surv_traceback #(.STATE_BITS(2), .COLS(COLS), .FIXED_START(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .in_dec(dec_a), .in_best(best_a), .out_valid(ov_a), .out_ready(out_ready),
    .out_bit(ob_a), .out_ok(ok_a));

  surv_traceback #(.STATE_BITS(2), .COLS(COLS), .FIXED_START(1'b1)) dut_z (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_z),
    .in_dec(dec_z), .in_best(best_z), .out_valid(ov_z), .out_ready(out_ready),
    .out_bit(ob_z), .out_ok(ok_z));

  logic [3:0] sd_a [N];
  logic [3:0] sd_z [N];
  logic [1:0] sb_a [N];
  logic [1:0] sb_z [N];
  logic       su_a [N];
  logic       su_z [N];

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    logic [1:0] pa, pz, na, nz;
    logic       ua, uz;
    int         idx, k, cyc;
    bit         mv, hold, exp_ok, exp_rdy;
    logic       hb_a, hb_z, hok_a, hok_z;

    // Encoder paths: the new bit enters the state's top bit (R5).
    pa = '0; pz = '0;
    for (int t = 0; t < N; t++) begin
      ua = 1'($urandom_range(0, 1));
      uz = 1'($urandom_range(0, 1));
      if ((t % COLS) >= COLS - 2) uz = 1'b0; // path of dut_z is in state 0 at every bank end (R7)
      na = {ua, pa[1]};
      nz = {uz, pz[1]};
      sd_a[t] = 4'($urandom);
      sd_a[t][na] = pa[0];
      sd_z[t] = 4'($urandom);
      sd_z[t][nz] = pz[0];
      sb_a[t] = ((t % COLS) == COLS - 1) ? na : 2'($urandom); // only the last column counts (R6)
      sb_z[t] = 2'($urandom);
      su_a[t] = ua;
      su_z[t] = uz;
      pa = na;
      pz = nz;
    end

    repeat (3) @(negedge clk);
    check(ov_a == 1'b0 && ov_z == 1'b0, "R9 out_valid in reset", int'(ov_a), 0);
    check(rdy_a == 1'b1 && rdy_z == 1'b1, "R9 in_ready in reset", int'(rdy_a), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ov_a == 1'b0 && ok_a == 1'b0, "R9 idle after reset", int'(ov_a), 0);
    check(rdy_a == 1'b1, "R9 ready after reset", int'(rdy_a), 1);

    idx = 0; k = 0; cyc = 0; mv = 1'b0; hold = 1'b0;
    hb_a = 1'b0; hb_z = 1'b0; hok_a = 1'b0; hok_z = 1'b0;
    while (k < N && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc < 300) begin
        in_valid  = (idx < N);
        out_ready = 1'b1;
      end else begin
        in_valid  = (idx < N) && ($urandom_range(0, 3) != 0);
        out_ready = ($urandom_range(0, 2) != 0);
      end
      if (idx < N) begin
        dec_a  = sd_a[idx];
        dec_z  = sd_z[idx];
        best_a = sb_a[idx];
        best_z = sb_z[idx];
      end
      #1;
      exp_rdy = !mv || out_ready;
      check(rdy_a == exp_rdy, "R1 in_ready", int'(rdy_a), int'(exp_rdy));
      check(rdy_z == exp_rdy, "R1 in_ready fixed-start copy", int'(rdy_z), int'(exp_rdy));
      check(ov_a == mv && ov_z == mv, "R2 out_valid", int'(ov_a), int'(mv));
      if (hold) begin
        check(ob_a == hb_a && ok_a == hok_a, "R3 held beat", int'({ok_a, ob_a}), int'({hok_a, hb_a}));
        check(ob_z == hb_z && ok_z == hok_z, "R3 held beat fixed-start copy", int'({ok_z, ob_z}), int'({hok_z, hb_z}));
      end
      if (ov_a && out_ready) begin
        exp_ok = (k >= LAT);
        check(ok_a == exp_ok && ok_z == exp_ok, "R8 out_ok", int'(ok_a), int'(exp_ok));
        if (exp_ok) begin
          check(ob_a == su_a[k-LAT], "R4 R5 R6 decoded bit", int'(ob_a), int'(su_a[k-LAT]));
          check(ob_z == su_z[k-LAT], "R7 R4 decoded bit from state 0", int'(ob_z), int'(su_z[k-LAT]));
        end
        k++;
      end
      hold  = ov_a && !out_ready;
      hb_a  = ob_a; hb_z = ob_z; hok_a = ok_a; hok_z = ok_z;
      if (in_valid && rdy_a) begin
        mv = 1'b1;
        idx++;
      end else if (out_ready) begin
        mv = 1'b0;
      end
    end

    if (k < N) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: output beats actual=%0d expected=%0d", k, N);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule